// File: doc/BRIEF.md
# Replicated Clock-Enable Pulse Generator

This block turns one fast system clock into a periodic clock-enable so that most of a design can run at a fraction of the system rate while every flip-flop stays on the same physical clock. With the default settings a one-cycle pulse appears once every five system cycles, so a 250 MHz clock gives an effective 50 MHz rate. No divided clock net exists anywhere; the slow logic simply samples its clock-enable pins.

A modulo counter runs from 0 to the ratio minus one and wraps. The pulse is decoded one state before the terminal count and captured by several identical flip-flops, one per output copy. Each copy then drives only its own share of the enabled load (about 30 of 150 flops with the defaults), and the path into every clock-enable pin starts at a register. Because of the extra register stage the pulses still land in the terminal-count cycle. An optional terminal-count flag, decoded straight from the counter, can be brought out for logic that wants the unregistered view.

Top module: `clken_fanout_gen`

## Requirements
- R1: While reset is inactive, the enable copies are high exactly once in every DIV_RATIO consecutive system cycles, at a fixed phase.
- R2: Each enable pulse lasts exactly one system-clock cycle; the cycle after a pulse has all copies low.
- R3: All N_COPIES enable outputs are identical in every cycle: either all low or all high.
- R4: After reset is released, counting rising edges with reset sampled high from 1, the enables are first high after edge DIV_RATIO-1 and then after every further DIV_RATIO edges (edge k gives a pulse when k mod DIV_RATIO equals DIV_RATIO-1).
- R5: Reset is synchronous and active-low: an edge with reset low clears the counter and drives every enable copy and the terminal-count flag low, even if a pulse was due on that edge; after release the sequence of R4 restarts.
- R6: When TC_EN is 1, the terminal-count flag is high in exactly the cycles in which the enable copies are high.
- R7: When TC_EN is 0, the terminal-count flag is held low in every cycle.
- R8: DIV_RATIO (at least 2) and N_COPIES are parameters with defaults of 5 and 5; smaller ratios such as 2 follow R1 to R4 with the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the only clock of the block |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_o | output | N_COPIES | Replicated clock-enable copies, each straight from a flip-flop |
| tc_o | output | 1 | Terminal-count flag (held low when TC_EN is 0) |

## Verification
The bench builds two instances on one clock and reset: the defaults (ratio 5, five copies, flag enabled) and a ratio of 2 with three copies and the flag disabled. The default instance reaches the first-pulse latency, the five-cycle period, copy agreement and the flag alignment, including a reset asserted on the very edge where a pulse was due. The ratio-2 instance reaches the smallest legal counter, where the early decode is count zero and pulses alternate every cycle, and shows the disabled flag staying low.

// File: rtl/cegen_pkg.sv
// Package: shared defaults and the counter step for the clock-enable generator.
// Assumes a ratio of at least 2 so that an early decode state exists.
package cegen_pkg;

    localparam int unsigned CEGEN_DEF_DIV    = 5;
    localparam int unsigned CEGEN_DEF_COPIES = 5;

    // Next value of a modulo-div counter.
    function automatic int unsigned cegen_next(input int unsigned cur,
                                               input int unsigned div);
        if (cur >= div - 1)
            return 0;
        return cur + 1;
    endfunction

endpackage

// File: rtl/cegen_counter.sv
// Module: modulo counter with an early decode one state before terminal count
// and an optional terminal-count decode.
// Assumes DIV_RATIO >= 2 and a synchronous active-low reset.
module cegen_counter
    import cegen_pkg::*;
#(
    parameter int unsigned DIV_RATIO = CEGEN_DEF_DIV,
    parameter bit          TC_EN     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    output logic early_o,
    output logic term_o
);

    localparam int unsigned CW       = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST   = CW'(DIV_RATIO - 1);
    localparam logic [CW-1:0] BEFORE = CW'(DIV_RATIO - 2);

    logic [CW-1:0] cnt;

    initial assert (DIV_RATIO >= 2);

    // Step the counter, wrapping after the last state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= CW'(cegen_next(32'(cnt), DIV_RATIO));
    end

    // Early decode feeding the replica registers.
    always_comb early_o = (cnt == BEFORE);

    generate
        if (TC_EN) begin : g_tc
            // Terminal-count decode taken straight from the counter.
            always_comb term_o = (cnt == LAST);
        end else begin : g_no_tc
            // Flag disabled: tie low.
            always_comb term_o = 1'b0;
        end
    endgenerate

    // R1: counter stays inside its modulo range.
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R1: the last state is followed by zero.
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));

    // R5: a reset edge leaves the counter at zero.
    a_r5_cnt_cleared: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0));

endmodule

// File: rtl/cegen_replica.sv
// Module: one registered copy of the enable, driving its own share of load.
// Assumes the input pulse is one cycle wide and never back-to-back.
module cegen_replica (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    // Capture the early pulse so it lands on the terminal-count cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else
            q_o <= d_i;
    end

    // R2: a pulse never lasts more than one cycle.
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        q_o |=> !q_o);

    // R5: a reset edge clears the copy.
    a_r5_copy_cleared: assert property (@(posedge clk)
        !rst_n |=> !q_o);

endmodule

// File: rtl/clken_fanout_gen.sv
// Module: top of the replicated clock-enable generator. One counter, N_COPIES
// parallel enable registers, optional terminal-count flag.
// Assumes a single clock domain and DIV_RATIO >= 2.
module clken_fanout_gen
    import cegen_pkg::*;
#(
    parameter int unsigned DIV_RATIO = CEGEN_DEF_DIV,
    parameter int unsigned N_COPIES  = CEGEN_DEF_COPIES,
    parameter bit          TC_EN     = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [N_COPIES-1:0] ce_o,
    output logic                tc_o
);

    logic early;
    logic term;

    cegen_counter #(
        .DIV_RATIO (DIV_RATIO),
        .TC_EN     (TC_EN)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .early_o (early),
        .term_o  (term)
    );

    generate
        for (genvar g = 0; g < int'(N_COPIES); g++) begin : g_copy
            cegen_replica u_rep (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (early),
                .q_o   (ce_o[g])
            );
        end
    endgenerate

    // Bring the flag out unchanged.
    always_comb tc_o = term;

    // R3: every copy agrees.
    a_r3_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o == '0) || (ce_o == '1));

    generate
        if (TC_EN) begin : g_chk_tc
            // R6: registered copies line up with the direct decode.
            a_r6_tc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
                tc_o == ce_o[0]);
        end else begin : g_chk_no_tc
            // R7: disabled flag stays low.
            a_r7_tc_low: assert property (@(posedge clk) disable iff (!rst_n)
                !tc_o);
        end
    endgenerate

endmodule

// File: tb/tb_clken_fanout_gen.sv
module tb_clken_fanout_gen;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] ce_a;
    logic       tc_a;
    logic [2:0] ce_b;
    logic       tc_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    clken_fanout_gen dut (
        .clk (clk), .rst_n (rst_n), .ce_o (ce_a), .tc_o (tc_a)
    );

    clken_fanout_gen #(.DIV_RATIO(2), .N_COPIES(3), .TC_EN(1'b0)) dut_b (
        .clk (clk), .rst_n (rst_n), .ce_o (ce_b), .tc_o (tc_b)
    );

    // Expected default-instance enable after edges 1..12 since release.
    localparam logic [0:11] EXP_A = 12'b0001_0000_1000;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        // Reset state.
        repeat (3) @(negedge clk);
        chk("R5 reset ce", 32'(ce_a), 32'h0);
        chk("R5 reset tc", 32'(tc_a), 32'h0);
        chk("R5 reset ce_b", 32'(ce_b), 32'h0);
        rst_n = 1'b1;

        // Table walk: edges 1..12 after release.
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            chk("R4 R1 first pulse and period", 32'(ce_a), EXP_A[k-1] ? 32'h1f : 32'h0);
            chk("R3 copies agree", 32'((ce_a == '0) || (ce_a == '1)), 32'h1);
            chk("R6 tc aligned", 32'(tc_a), 32'(EXP_A[k-1]));
            chk("R8 R1 ratio 2", 32'(ce_b), (k % 2 == 1) ? 32'h7 : 32'h0);
            chk("R7 tc disabled", 32'(tc_b), 32'h0);
            if (k > 1)
                chk("R2 single cycle", 32'(EXP_A[k-1] && EXP_A[k-2]), 32'h0);
        end

        // Edge 13: counter at 3; assert reset so edge 14 (a pulse edge) is blocked.
        @(negedge clk);
        chk("R1 pre-reset quiet", 32'(ce_a), 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R5 pulse suppressed by reset", 32'(ce_a), 32'h0);
        chk("R5 tc cleared", 32'(tc_a), 32'h0);
        chk("R5 ce_b cleared", 32'(ce_b), 32'h0);
        @(negedge clk);
        chk("R5 still clear", 32'(ce_a), 32'h0);
        rst_n = 1'b1;

        // Sequence restarts as after the first release.
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R5 R4 restart", 32'(ce_a), (k % 5 == 4) ? 32'h1f : 32'h0);
            chk("R6 tc after restart", 32'(tc_a), (k % 5 == 4) ? 32'h1 : 32'h0);
        end

        // Long run: count pulses over 100 cycles.
        begin
            int pulses = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (ce_a == 5'h1f) pulses++;
            end
            chk("R1 pulse count per 100 cycles", 32'(pulses), 32'd20);
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule